// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital half of a two-channel, 8-bit successive-approximation converter. The serial port has three wires: active-low select, serial clock and data in. A host uses it to pick an input configuration and then read back a conversion. The bench stands in for the analog parts: the comparator, the DAC and the input multiplexer.

The block runs on a fast system clock. It synchronizes the serial clock, the select line and the data line, and works on the detected serial-clock edges.

A transaction has three phases:
- **Configuration.** After select falls, the host shifts in a logic-1 start bit on a rising edge, then two configuration bits on the next two rising edges. These bits drive the multiplexer controls.
- **Conversion.** Half a serial period later, on the next falling edge, the data-out line is enabled. Each of the eight following falling edges resolves one bit from MSB to LSB, using the comparator decision against the DAC trial code. That bit appears on data-out in the same edge.
- **Replay.** The stored result is then sent again LSB first, without repeating the shared LSB. After that, data-out is released.

Taking select high clears everything. A one-cycle done pulse and a parallel copy of the result are also available.

Top module: `serial_sar_ctrl`

## Requirements
- R1: While the synchronized select is high, all state is cleared within one system cycle: `dout_en`=0, `mux_valid`=0, `dac_code`=0 and `result`=0. This aborts any conversion in progress.
- R2: Rising serial-clock edges that sample `din`=0 before the start bit are ignored. The first rising edge that samples `din`=1 is the start bit.
- R3: The two rising edges after the start bit capture, in order, the mode bit and the channel bit, and `mux_valid` goes high. Mode 1 is single-ended: `mux_neg_gnd`=1 and the channel bit picks the positive channel (0 selects channel 0, 1 selects channel 1). Mode 0 is differential: `mux_neg_gnd`=0, channel bit 0 puts channel 0 on plus and channel 1 on minus, and channel bit 1 swaps them. In every case `mux_pos_ch` equals the channel bit.
- R4: On the first falling edge after the channel bit, `dout_en` goes to 1 and `dout` is 0 for that serial period.
- R5: Conversion tries each bit from MSB to LSB. The trial bit is set in `dac_code` and kept only when `cmp_hi`=1 at the deciding falling edge, where `cmp_hi` means the input is at or above the trial level. The kth falling edge after the one in R4 decides bit 8-k, and after the eighth, `dac_code` equals the result.
- R6: Each decided bit is driven on `dout` at the falling edge that decides it, MSB first.
- R7: When the positive input is below the negative input, the result is all zeros.
- R8: The next seven falling edges drive result bits 1 through 7, in that order. Bit 0 is not sent a second time.
- R9: The falling edge after the last replayed bit sets `dout_en` to 0, and it stays 0 until select goes high.
- R10: `done` pulses for exactly one system cycle when the LSB is decided. `result` holds the converted value from then until select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in (start and configuration bits) |
| cmp_hi | input | 1 | Comparator: input at or above the DAC trial level |
| dout | output | 1 | Serial data out value |
| dout_en | output | 1 | Output enable for data out (0 means high impedance) |
| dac_code | output | W | Trial code driven to the DAC |
| mux_valid | output | 1 | Multiplexer configuration captured |
| mux_pos_ch | output | 1 | Channel routed to the positive comparator input |
| mux_neg_gnd | output | 1 | Negative comparator input tied to ground (single-ended mode) |
| result | output | W | Parallel copy of the conversion result |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
The sweep runs every mux configuration against an 8-by-8 grid of channel levels. The grid includes equal inputs, full scale, and negative differences. A swapped polarity or channel decode shows up as a wrong or clipped code, and a comparator sense error shows up as a result that is off by one.

The bench puts leading zero clocks before the start bit in some transactions. A controller that took any rising edge as the start would then misread the configuration.

The LSB-first tail is compared bit by bit. A controller that repeats the LSB, or keeps driving after the tail, fails both the replay check and the release check.

A transaction is also abandoned mid-conversion. The next one then shows whether stale trial state survives the select-high clear.

// File: rtl/serial_sar_ctrl.sv
module serial_sar_ctrl #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         din,
  input  logic         cmp_hi,
  output logic         dout,
  output logic         dout_en,
  output logic [W-1:0] dac_code,
  output logic         mux_valid,
  output logic         mux_pos_ch,
  output logic         mux_neg_gnd,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [2:0] {P_IDLE, P_MODE, P_CHAN, P_SETTLE, P_CONV, P_REPLAY, P_QUIET} phase_t;

  phase_t          phase;
  logic [SYNC-1:0] sclk_s, cs_s, din_s;
  logic            sclk_d;
  logic            sclk_q, cs_q, din_q, rise, fall;
  logic [W-1:0]    mask, shreg, decided, next_code;
  logic [CW-1:0]   left;

  assign sclk_q = sclk_s[SYNC-1];
  assign cs_q   = cs_s[SYNC-1];
  assign din_q  = din_s[SYNC-1];
  assign rise   = sclk_q & ~sclk_d;
  assign fall   = ~sclk_q & sclk_d;

  assign decided   = (dac_code & ~mask) | (cmp_hi ? mask : '0);
  assign next_code = decided | (mask >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      din_s  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[SYNC-2:0], sclk};
      cs_s   <= {cs_s[SYNC-2:0], cs_n};
      din_s  <= {din_s[SYNC-2:0], din};
      sclk_d <= sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= P_IDLE;
      mux_valid   <= 1'b0;
      mux_pos_ch  <= 1'b0;
      mux_neg_gnd <= 1'b0;
      dout        <= 1'b0;
      dout_en     <= 1'b0;
      dac_code    <= '0;
      mask        <= '0;
      shreg       <= '0;
      left        <= '0;
      result      <= '0;
      done        <= 1'b0;
    end else if (cs_q) begin
      phase       <= P_IDLE;
      mux_valid   <= 1'b0;
      mux_pos_ch  <= 1'b0;
      mux_neg_gnd <= 1'b0;
      dout        <= 1'b0;
      dout_en     <= 1'b0;
      dac_code    <= '0;
      mask        <= '0;
      shreg       <= '0;
      left        <= '0;
      result      <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        P_IDLE:
          if (rise && din_q) phase <= P_MODE;
        P_MODE:
          if (rise) begin
            mux_neg_gnd <= din_q;
            phase       <= P_CHAN;
          end
        P_CHAN:
          if (rise) begin
            mux_pos_ch <= din_q;
            mux_valid  <= 1'b1;
            phase      <= P_SETTLE;
          end
        P_SETTLE:
          if (fall) begin
            dout_en  <= 1'b1;
            dout     <= 1'b0;
            dac_code <= MSB;
            mask     <= MSB;
            phase    <= P_CONV;
          end
        P_CONV:
          if (fall) begin
            dout     <= cmp_hi;
            dac_code <= next_code;
            mask     <= mask >> 1;
            if (mask[0]) begin
              result <= decided;
              shreg  <= decided >> 1;
              left   <= CW'(W - 1);
              done   <= 1'b1;
              phase  <= P_REPLAY;
            end
          end
        P_REPLAY:
          if (fall) begin
            dout  <= shreg[0];
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
            if (left == CW'(1)) phase <= P_QUIET;
          end
        P_QUIET:
          if (fall) dout_en <= 1'b0;
        default: phase <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_sar_ctrl_chk.sv
module serial_sar_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_q,
  input logic         dout_en,
  input logic         mux_valid,
  input logic         mux_pos_ch,
  input logic         mux_neg_gnd,
  input logic         done,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] result
);
  p_clear_on_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> (!dout_en && !mux_valid && dac_code == '0 && result == '0));

  p_cfg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_valid && $past(mux_valid) && !cs_q && !$past(cs_q)) |-> ($stable(mux_pos_ch) && $stable(mux_neg_gnd)));

  p_drive_after_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> mux_valid);

  p_code_matches_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dac_code == result));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !cs_q && !$past(cs_q)) |-> $stable(result));
endmodule

bind serial_sar_ctrl serial_sar_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .dout_en(dout_en), .mux_valid(mux_valid),
  .mux_pos_ch(mux_pos_ch), .mux_neg_gnd(mux_neg_gnd), .done(done),
  .dac_code(dac_code), .result(result)
);

// File: tb/test_serial_sar_ctrl.sv
module test_serial_sar_ctrl;
  localparam int H = 8;

  logic       clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic       cmp_hi, dout, dout_en, mux_valid, mux_pos_ch, mux_neg_gnd, done;
  logic [7:0] dac_code, result;
  int ch0 = 0, ch1 = 0, vp, vn;
  int n_chk = 0, n_bad = 0, done_cnt = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    vp     = mux_pos_ch ? ch1 : ch0;
    vn     = mux_neg_gnd ? 0 : (mux_pos_ch ? ch0 : ch1);
    cmp_hi = (vp - vn) >= int'(dac_code);
  end

  always @(posedge clk) if (done) done_cnt++;

  serial_sar_ctrl i_serial_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_hi(cmp_hi),
    .dout(dout), .dout_en(dout_en), .dac_code(dac_code), .mux_valid(mux_valid),
    .mux_pos_ch(mux_pos_ch), .mux_neg_gnd(mux_neg_gnd), .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic d);
    din = d;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input int a, input int b, input bit sgl, input bit odd, input int lead);
    int p, n, e, d0;
    logic [7:0] ev, got_msb, got_lsb;
    bit oe_ok;
    ch0 = a;
    ch1 = b;
    p = odd ? b : a;
    n = sgl ? 0 : (odd ? a : b);
    e = (p > n) ? p - n : 0;
    ev = 8'(e);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    d0 = done_cnt;
    for (int i = 0; i < lead; i++) pulse(1'b0);
    if (lead > 0) check(!dout_en && !mux_valid, "R2", int'({dout_en, mux_valid}), 0);
    pulse(1'b1);
    pulse(sgl);
    pulse(odd);
    check(dout_en === 1'b1 && dout === 1'b0, "R4", int'({dout_en, dout}), 2);
    check(mux_valid === 1'b1 && mux_neg_gnd === sgl && mux_pos_ch === odd, "R3",
          int'({mux_valid, mux_neg_gnd, mux_pos_ch}), int'({1'b1, sgl, odd}));
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0);
      got_msb[7-i] = dout;
      if (dout_en !== 1'b1) oe_ok = 1'b0;
    end
    if (p < n) check(got_msb === ev, "R7", int'(got_msb), int'(ev));
    else       check(got_msb === ev, "R6", int'(got_msb), int'(ev));
    check(dac_code === ev, "R5", int'(dac_code), int'(ev));
    check(result === ev && done_cnt == d0 + 1, "R10", int'(result), int'(ev));
    got_lsb[0] = got_msb[0];
    for (int i = 1; i < 8; i++) begin
      pulse(1'b0);
      got_lsb[i] = dout;
      if (dout_en !== 1'b1) oe_ok = 1'b0;
    end
    check(got_lsb === ev && oe_ok, "R8", int'(got_lsb), int'(ev));
    pulse(1'b0);
    check(dout_en === 1'b0, "R9", int'(dout_en), 0);
    pulse(1'b0);
    check(dout_en === 1'b0 && result === ev && done_cnt == d0 + 1, "R9", int'(dout_en), 0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!dout_en && !mux_valid && result == 8'd0 && dac_code == 8'd0, "R1",
          int'(result) + int'(dac_code) + int'(mux_valid) + int'(dout_en), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(dout_en === 1'b0 && done === 1'b0 && result === 8'd0, "R1", int'(result), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b1);
    pulse(1'b0);
    pulse(1'b1);
    ch0 = 200; ch1 = 10;
    pulse(1'b0);
    pulse(1'b0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!dout_en && !mux_valid && dac_code == 8'd0, "R1", int'(dac_code), 0);

    for (int cfg = 0; cfg < 4; cfg++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          xfer((ia == 7) ? 255 : ia * 36, (ib == 7) ? 255 : ib * 36 + (ib % 2),
               cfg[1], cfg[0], (ia + ib) % 3);

    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule